// File: doc/BRIEF.md
# External Interrupt Sense Conditioner

This block sits between a set of external interrupt pins and the interrupt controller's request logic. Every pin first passes through a two-flop synchroniser. A per-pin sense bit then selects one of two modes. In level mode the pin is active low. In edge mode a high-to-low transition sets a sticky pending bit. No rising-edge or active-high mode exists.

Software reaches three registers on a simple word-addressed register bus: a sense-configuration register, a pending register and a mask register. In edge mode, software clears pending bits by writing 1 to them. The block drives one request line per pin, qualified by the mask. Priority resolution and vector generation happen downstream.

Top module: `eis_sense_top`

## Requirements
- R1: After reset the sense, pending and mask registers read 0, every request output is 0, and every pin behaves as an active-low level source.
- R2: The sense register is at address 0. Pin n's mode bit is at bit 15-n, so pin 0 uses bit 15 and pin 7 uses bit 8. The value 1 selects falling-edge mode and 0 selects low-level mode. All other bits read 0 and ignore writes.
- R3: In level mode, pin n's pending bit is at bit 31-n of the pending register (address 1). It shows the inverted pin three clock edges after the pin changes, and not earlier.
- R4: In level mode, writing 1 to a pending bit has no lasting effect while the pin stays low.
- R5: In edge mode, a falling edge sets the pending bit three clock edges after the pin falls. The bit stays set after the pin returns high.
- R6: In edge mode, writing 1 to a pending bit clears it. Writing 0 to it leaves it unchanged.
- R7: If a falling edge and a write-1 clear of the same pin hit the same clock edge, the pending bit stays set.
- R8: In edge mode, a rising edge never sets a pending bit.
- R9: The mask register is at address 2, with pin n's bit at bit 31-n; 1 enables the request and 0 blocks it. The request output irq_req[n] is high exactly when pin n is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin_n | input | NPINS | Asynchronous external interrupt pins, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 sense, 1 pending, 2 mask |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq_req | output | NPINS | Per-pin request, pending and enabled |

## Verification
The bench builds the block with its default values: eight pins, a 32-bit data path and the sense field topped at bit 15. With these values the first pin and the last pin, and therefore both ends of the downward sense layout and of the MSB-first pending layout, can be reached with directed pin waveforms. The latency tests sample one cycle before the expected change and again at the change, which pins down the synchroniser depth. The race between an edge and a clear is set up by timing the clear write to land on the edge-detect cycle.

// File: rtl/eis_pkg.sv
package eis_pkg;
  // Word addresses on the register bus
  typedef enum logic [1:0] {
    REG_SENSE = 2'd0,
    REG_PEND  = 2'd1,
    REG_MASK  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  // Reset to all ones: an idle pin is high, i.e. inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/eis_pin_cell.sv
module eis_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,      // synchronised pin, active low
  input  logic edge_mode,  // 1 falling edge, 0 low level
  input  logic clr,        // write-1 clear strobe
  output logic pend,
  output logic fall_evt
);
  logic prev_q;
  logic pend_q;
  logic pend_d;

  always_comb begin
    fall_evt = prev_q & ~pin_s;
    if (edge_mode) begin
      // edge has priority over a clear in the same cycle
      pend_d = fall_evt | (pend_q & ~clr);
    end else begin
      pend_d = ~pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import eis_pkg::*;
#(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SENSE_MSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  pend_vec,
  output logic [NPINS-1:0]  sense_vec,
  output logic [NPINS-1:0]  mask_vec,
  output logic [NPINS-1:0]  clr_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned TOP_BIT = DATA_W - 1;

  logic [NPINS-1:0] sense_q, sense_d;
  logic [NPINS-1:0] mask_q,  mask_d;
  logic             sense_en, mask_en, pend_wr;
  logic [NPINS-1:0] wsense, wmsb;
  logic [DATA_W-1:0] sense_word, pend_word, mask_word;
  reg_sel_e          sel;
  logic              unused_wbits;

  assign sel      = reg_sel_e'(addr);
  assign sense_en = wr && (sel == REG_SENSE);
  assign mask_en  = wr && (sel == REG_MASK);
  assign pend_wr  = wr && (sel == REG_PEND);

  for (genvar g = 0; g < NPINS; g++) begin : g_lane
    assign wsense[g]  = wdata[SENSE_MSB - g];
    assign wmsb[g]    = wdata[TOP_BIT - g];
    assign clr_vec[g] = pend_wr & wmsb[g];
  end

  assign unused_wbits = &{1'b0, wdata};

  always_comb begin
    sense_d = sense_en ? wsense : sense_q;
    mask_d  = mask_en  ? wmsb   : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else begin
      sense_q <= sense_d;
      mask_q  <= mask_d;
    end
  end

  always_comb begin
    sense_word = '0;
    pend_word  = '0;
    mask_word  = '0;
    for (int i = 0; i < NPINS; i++) begin
      sense_word[SENSE_MSB - i] = sense_q[i];
      pend_word[TOP_BIT - i]    = pend_vec[i];
      mask_word[TOP_BIT - i]    = mask_q[i];
    end
    case (sel)
      REG_SENSE: rdata = sense_word;
      REG_PEND:  rdata = pend_word;
      REG_MASK:  rdata = mask_word;
      default:   rdata = '0;
    endcase
  end

  assign sense_vec = sense_q;
  assign mask_vec  = mask_q;
endmodule

// File: rtl/eis_sense_top.sv
module eis_sense_top #(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SENSE_MSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  ext_pin_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NPINS-1:0]  irq_req
);
  logic             rst_meta_q, rst_sync_n;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pend_vec, fall_vec;
  logic [NPINS-1:0] sense_vec, mask_vec, clr_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  eis_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (ext_pin_n),
    .sync_out (pin_sync)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    eis_pin_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pin_s     (pin_sync[g]),
      .edge_mode (sense_vec[g]),
      .clr       (clr_vec[g]),
      .pend      (pend_vec[g]),
      .fall_evt  (fall_vec[g])
    );
  end

  eis_regs #(
    .NPINS     (NPINS),
    .DATA_W    (DATA_W),
    .SENSE_MSB (SENSE_MSB)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .pend_vec  (pend_vec),
    .sense_vec (sense_vec),
    .mask_vec  (mask_vec),
    .clr_vec   (clr_vec),
    .rdata     (reg_rdata)
  );

  assign irq_req = pend_vec & mask_vec;
endmodule

// File: rtl/eis_sense_checker.sv
module eis_sense_checker #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_sync,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] fall,
  input logic [NPINS-1:0] sense,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] clr,
  input logic [NPINS-1:0] req
);
  // R9: no request on a blocked pin, and every pending enabled pin requests
  assert_req_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~mask) == '0) && ((pend & mask & ~req) == '0));

  // R3: level-mode pending follows the inverted synchronised pin
  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(~sense) & (pend ^ ~$past(pin_sync))) == '0));

  // R5: an edge-mode pending bit with no clear stays set
  assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sense & pend & ~clr) & ~pend) == '0));

  // R7: an edge always leaves the bit set, clear or not
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sense & fall) & ~pend) == '0));

  // R6: a clear without an edge empties the bit
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sense & clr & ~fall) & pend) == '0));

  // R8: in edge mode a bit only becomes set through a falling edge
  assert_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sense & ~pend & ~fall) & pend) == '0));
endmodule

bind eis_sense_top eis_sense_checker #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pin_sync (pin_sync),
  .pend     (pend_vec),
  .fall     (fall_vec),
  .sense    (sense_vec),
  .mask     (mask_vec),
  .clr      (clr_vec),
  .req      (irq_req)
);

// File: tb/tb_eis_sense_top.sv
`timescale 1ns/1ps
module tb_eis_sense_top;
  localparam int unsigned NP = 8;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pins;
  logic          wr;
  logic [1:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NP-1:0] req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  eis_sense_top dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(pins), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_req(req)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rchk(input string tag, input logic [1:0] a, input logic [DW-1:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rchk("R1 sense", 2'd0, 32'h0);
    rchk("R1 pend",  2'd1, 32'h0);
    rchk("R1 mask",  2'd2, 32'h0);
    chk("R1 req", {24'h0, req}, 32'h0);
    // default level mode: a low pin shows pending
    @(negedge clk); pins[0] = 1'b0;
    cyc(3);
    rchk("R1 level default", 2'd1, 32'h8000_0000);
    pins[0] = 1'b1;
    cyc(3);
    rchk("R1 release", 2'd1, 32'h0);
  endtask

  task automatic t_layout;
    wreg(2'd0, 32'hFFFF_FFFF);
    rchk("R2 writable bits", 2'd0, 32'h0000_FF00);
    wreg(2'd0, 32'h0);
    rchk("R2 cleared", 2'd0, 32'h0);
  endtask

  task automatic t_level;
    wreg(2'd2, 32'hFF00_0000);
    @(negedge clk); pins[3] = 1'b0;
    cyc(2);
    rchk("R3 not yet", 2'd1, 32'h0);
    cyc(1);
    rchk("R3 low seen", 2'd1, 32'h1000_0000);
    chk("R9 req enabled", {24'h0, req}, 32'h08);
    pins[3] = 1'b1;
    cyc(3);
    rchk("R3 high seen", 2'd1, 32'h0);
  endtask

  task automatic t_level_clear;
    @(negedge clk); pins[5] = 1'b0;
    cyc(3);
    wreg(2'd1, 32'h0400_0000);
    cyc(1);
    rchk("R4 clear ignored", 2'd1, 32'h0400_0000);
    pins[5] = 1'b1;
    cyc(3);
    rchk("R4 release", 2'd1, 32'h0);
  endtask

  task automatic t_edge;
    wreg(2'd0, 32'h0000_2000);   // pin2 edge mode (bit 13)
    @(negedge clk); pins[2] = 1'b0;
    cyc(3);
    rchk("R5 edge set", 2'd1, 32'h2000_0000);
    pins[2] = 1'b1;
    cyc(4);
    rchk("R5 sticky", 2'd1, 32'h2000_0000);
    wreg(2'd1, 32'h0);
    rchk("R6 write0 keeps", 2'd1, 32'h2000_0000);
    wreg(2'd1, 32'h2000_0000);
    rchk("R6 write1 clears", 2'd1, 32'h0);
  endtask

  task automatic t_rise;
    @(negedge clk); pins[2] = 1'b0;
    cyc(3);
    wreg(2'd1, 32'h2000_0000);
    rchk("R8 cleared while low", 2'd1, 32'h0);
    pins[2] = 1'b1;
    cyc(4);
    rchk("R8 rise ignored", 2'd1, 32'h0);
  endtask

  task automatic t_race;
    @(negedge clk); pins[2] = 1'b0;
    cyc(3);
    pins[2] = 1'b1;
    cyc(4);
    rchk("R7 preset", 2'd1, 32'h2000_0000);
    pins[2] = 1'b0;              // edge-detect lands on the third edge
    repeat (2) @(posedge clk);
    wreg(2'd1, 32'h2000_0000);   // clear on the same edge
    rchk("R7 edge wins", 2'd1, 32'h2000_0000);
    cyc(1);
    rchk("R7 still set", 2'd1, 32'h2000_0000);
    pins[2] = 1'b1;
  endtask

  task automatic t_mask;
    wreg(2'd2, 32'h0);
    chk("R9 blocked", {24'h0, req}, 32'h0);
    rchk("R9 pend kept", 2'd1, 32'h2000_0000);
    wreg(2'd2, 32'h2000_0000);
    chk("R9 enabled", {24'h0, req}, 32'h04);
    rchk("R9 mask read", 2'd2, 32'h2000_0000);
  endtask

  task automatic t_pin7;
    wreg(2'd0, 32'h0000_0100);   // pin7 edge (bit 8), pin2 back to level
    cyc(1);
    rchk("R2 pin2 level again", 2'd1, 32'h0);
    @(negedge clk); pins[7] = 1'b0;
    cyc(3);
    pins[7] = 1'b1;
    cyc(4);
    rchk("R2 pin7 edge bit24", 2'd1, 32'h0100_0000);
  endtask

  initial begin
    rst_n = 1'b0; pins = '1; wr = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_layout();
    t_level();
    t_level_clear();
    t_edge();
    t_rise();
    t_race();
    t_mask();
    t_pin7();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule